// File: doc/BRIEF.md
# Quasi-Bidirectional GPIO Port

This block is an eight-pin general-purpose I/O port with no direction register. Each pin owns one output latch. A latch holding 0 turns on the pin's pull-down, so the pin is driven low. A latch holding 1 turns the pull-down off, and the pin then rests high through a weak pull-up unless something outside pulls it low. Software therefore uses a pin as an input by first writing 1 to its latch and then reading the pin.

The CPU side of the block has a write strobe with a data word and two read strobes. The read-pin strobe returns the synchronized level seen at the pads. The read-latch strobe returns the stored latch values, which is the path a read-modify-write sequence must use. The pad side has, for each pin, a pull-down enable, a pull-up enable and a sampled input. A parameter selects the variant with an internal pull-up or the open-drain variant, which never enables the pull-up and relies on an external resistor.

Top module: `qbio_port`

## Requirements
- R1: While reset is asserted and after it is released, every latch holds 1 (0xFF for eight pins), every pull-down enable is 0, and every pull-up enable is 1 in the pull-up variant.
- R2: A latch loads wr_data only on a rising clock edge where wr_en is 1. With wr_en at 0, wr_data has no effect, and a read-latch returns the previous value.
- R3: From the clock edge that loads a latch onward, pad_pd_en[i] is 1 exactly when latch bit i is 0.
- R4: In the pull-up variant (PAD_KIND = PAD_WEAK_PULLUP), pad_pu_en[i] is 1 exactly when latch bit i is 1.
- R5: In the open-drain variant (PAD_KIND = PAD_OPEN_DRAIN), pad_pu_en is 0 on every pin whatever the latch holds.
- R6: pad_in passes through two clock stages before it reaches the read-pin path. A level set on pad_in appears on rd_data under rd_pin_en after the second rising edge, and not after only one.
- R7: With only rd_lat_en at 1, rd_data returns the latch contents, even where the pin level differs.
- R8: With rd_pin_en and rd_lat_en both at 1, rd_data returns the synchronized pin level.
- R9: With neither read strobe at 1, rd_data is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe that loads the latches |
| wr_data | input | WIDTH | Value to be written into the latches |
| rd_pin_en | input | 1 | Read strobe for the synchronized pin levels |
| rd_lat_en | input | 1 | Read strobe for the latch contents |
| rd_data | output | WIDTH | Read result, combinational from the strobes |
| pad_in | input | WIDTH | Level seen at each pin, asynchronous to clk |
| pad_pd_en | output | WIDTH | Pull-down enable for each pin |
| pad_pu_en | output | WIDTH | Weak pull-up enable for each pin |

## Verification
The assertions assume that the strobes and wr_data are synchronous to clk, and that pad_in stays stable for at least two clock edges whenever its synchronized value is compared against its past. They also assume that no write is issued in the cycle in which the internal reset is released. The stimulus changes pad_in only on falling edges and holds it for at least two rising edges before any pin read. Writes and reads are issued only after the internal reset has been released. Random writes, pad levels and strobe pairs are mixed with directed cases in which the latch and the pin disagree. A second instance in the open-drain variant receives the same stimulus.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  // Pad flavour: internal weak pull-up present or not
  typedef enum logic {
    PAD_WEAK_PULLUP = 1'b0,
    PAD_OPEN_DRAIN  = 1'b1
  } pad_kind_e;
endpackage

// File: rtl/qbio_rst_sync.sv
module qbio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/qbio_in_sync.sv
module qbio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);
  // Idle value of a pulled-up pin
  localparam logic [WIDTH-1:0] IDLE = {WIDTH{1'b1}};

  logic [WIDTH-1:0] st_q [STAGES];
  logic [WIDTH-1:0] st_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb st_d[s] = pin_i;
    end else begin : g_next
      always_comb st_d[s] = st_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[s] <= IDLE;
      else        st_q[s] <= st_d[s];
    end
  end

  assign sync_o = st_q[STAGES-1];

  // Cycles since reset release, saturating; used only to qualify the check
  logic [1:0] warm_q, warm_d;
  always_comb warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else        warm_q <= warm_d;
  end

  if (STAGES == 2) begin : g_chk
    // R6: two-stage latency from pad to the read-pin path
    p_sync_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd3) |-> (sync_o == $past(pin_i, 2)));
  end
endmodule

// File: rtl/qbio_out_latch.sv
module qbio_out_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] lat_o
);
  localparam logic [WIDTH-1:0] LAT_INIT = {WIDTH{1'b1}};

  logic [WIDTH-1:0] lat_q, lat_d;

  always_comb begin
    lat_d = lat_q;
    if (wr_en) lat_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= LAT_INIT;
    else        lat_q <= lat_d;
  end

  assign lat_o = lat_q;

  // R2: latch keeps its value when not strobed
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (lat_o == $past(lat_o)));
  // R2: latch takes the written word when strobed
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (lat_o == $past(wr_data)));
endmodule

// File: rtl/qbio_padctl.sv
module qbio_padctl
  import qbio_pkg::*;
#(
  parameter int unsigned WIDTH    = 8,
  parameter pad_kind_e   PAD_KIND = PAD_WEAK_PULLUP
) (
  input  logic [WIDTH-1:0] lat_i,
  output logic [WIDTH-1:0] pd_o,
  output logic [WIDTH-1:0] pu_o
);
  // A 0 in the latch pulls the pin to ground
  assign pd_o = ~lat_i;

  if (PAD_KIND == PAD_OPEN_DRAIN) begin : g_od
    assign pu_o = '0;
  end else begin : g_pu
    assign pu_o = lat_i;
  end
endmodule

// File: rtl/qbio_port.sv
module qbio_port
  import qbio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter pad_kind_e   PAD_KIND    = PAD_WEAK_PULLUP,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_pin_en,
  input  logic             rd_lat_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_pd_en,
  output logic [WIDTH-1:0] pad_pu_en
);
  logic             rst_n_int;
  logic [WIDTH-1:0] lat;
  logic [WIDTH-1:0] pin_sync;

  qbio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_int)
  );

  qbio_out_latch #(.WIDTH(WIDTH)) u_lat (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .lat_o   (lat)
  );

  qbio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .pin_i  (pad_in),
    .sync_o (pin_sync)
  );

  qbio_padctl #(.WIDTH(WIDTH), .PAD_KIND(PAD_KIND)) u_pad (
    .lat_i (lat),
    .pd_o  (pad_pd_en),
    .pu_o  (pad_pu_en)
  );

  // Read path: pin level wins over latch when both are strobed
  always_comb begin
    rd_data = '0;
    if (rd_pin_en)      rd_data = pin_sync;
    else if (rd_lat_en) rd_data = lat;
  end

  // R3: pull-down follows the inverse of the written word
  p_pd_follow_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_en |=> (pad_pd_en == ~$past(wr_data)));

  if (PAD_KIND == PAD_WEAK_PULLUP) begin : g_pu_chk
    // R4: pull-up follows the written word
    p_pu_follow_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
      wr_en |=> (pad_pu_en == $past(wr_data)));
  end

  // R7: latch read returns the word written on the previous edge
  p_rdlat_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_lat_en && !rd_pin_en && $past(wr_en) && $past(rst_n_int))
      |-> (rd_data == $past(wr_data)));
endmodule

// File: tb/sim_qbio_port.sv
module sim_qbio_port;
  import qbio_pkg::*;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wr_en, rd_pin_en, rd_lat_en;
  logic [W-1:0] wr_data, pad_in;
  logic [W-1:0] rd0, pd0, pu0, rd1, pd1, pu1;

  qbio_port #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_pin_en(rd_pin_en), .rd_lat_en(rd_lat_en), .rd_data(rd0),
    .pad_in(pad_in), .pad_pd_en(pd0), .pad_pu_en(pu0));

  qbio_port #(.WIDTH(W), .PAD_KIND(PAD_OPEN_DRAIN)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_pin_en(rd_pin_en), .rd_lat_en(rd_lat_en), .rd_data(rd1),
    .pad_in(pad_in), .pad_pd_en(pd1), .pad_pu_en(pu1));

  int errors = 0;
  int checks = 0;
  logic [W-1:0] m_lat, m_pad;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] f_rd(input logic [W-1:0] pin, input logic [W-1:0] lat,
                                        input logic rp, input logic rl);
    if (rp) return pin;
    if (rl) return lat;
    return '0;
  endfunction

  function automatic logic [W-1:0] f_pu(input logic [W-1:0] lat, input logic od);
    return od ? '0 : lat;
  endfunction

  task automatic write_port(input logic en, input logic [W-1:0] d);
    @(negedge clk); wr_en = en; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    if (en) m_lat = d;
    #1;
    chk("R3 pull-down u0", pd0, ~m_lat);
    chk("R3 pull-down u1", pd1, ~m_lat);
    chk("R4 pull-up", pu0, f_pu(m_lat, 1'b0));
    chk("R5 open-drain pull-up", pu1, f_pu(m_lat, 1'b1));
    rd_lat_en = 1'b1; #1;
    chk("R2 latch after write", rd0, m_lat);
    rd_lat_en = 1'b0;
  endtask

  task automatic drive_pad(input logic [W-1:0] d);
    @(negedge clk); pad_in = d;
    @(posedge clk);
    @(negedge clk); rd_pin_en = 1'b1; #1;
    chk("R6 one edge, old level", rd0, m_pad);
    @(posedge clk);
    @(negedge clk); #1;
    m_pad = d;
    chk("R6 two edges, new level", rd0, m_pad);
    rd_pin_en = 1'b0;
  endtask

  task automatic read_pair(input logic rp, input logic rl);
    @(negedge clk); rd_pin_en = rp; rd_lat_en = rl; #1;
    if (rp && rl)      chk("R8 both strobes", rd0, f_rd(m_pad, m_lat, rp, rl));
    else if (rp)       chk("R6 pin read", rd0, f_rd(m_pad, m_lat, rp, rl));
    else if (rl)       chk("R7 latch read", rd0, f_rd(m_pad, m_lat, rp, rl));
    else               chk("R9 no strobe", rd0, f_rd(m_pad, m_lat, rp, rl));
    chk("R8 open-drain read", rd1, f_rd(m_pad, m_lat, rp, rl));
    rd_pin_en = 1'b0; rd_lat_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    rst_n = 1'b0; wr_en = 1'b0; rd_pin_en = 1'b0; rd_lat_en = 1'b0;
    wr_data = '0; pad_in = '1;
    m_lat = '1; m_pad = '1;
    seed_v = $urandom(32'h51C0);
    #12;
    // R1: reset state
    chk("R1 pull-down in reset", pd0, '0);
    chk("R1 pull-up in reset", pu0, '1);
    chk("R5 open-drain pull-up in reset", pu1, '0);
    rd_lat_en = 1'b1; #1;
    chk("R1 latch in reset", rd0, 8'hFF);
    rd_lat_en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    rd_lat_en = 1'b1; #1;
    chk("R1 latch after release", rd0, 8'hFF);
    rd_lat_en = 1'b0;

    // Directed corners
    write_port(1'b1, 8'h00);
    write_port(1'b1, 8'hFF);
    write_port(1'b0, 8'hA5);   // R2: ignored without strobe
    drive_pad(8'h00);          // latch 1s, pins low externally
    read_pair(1'b1, 1'b0);     // R6: pins read 00
    read_pair(1'b0, 1'b1);     // R7: latch reads FF
    read_pair(1'b1, 1'b1);     // R8
    read_pair(1'b0, 1'b0);     // R9
    write_port(1'b1, 8'h3C);
    drive_pad(8'hC3);
    read_pair(1'b1, 1'b1);

    // Constrained random mix
    for (int i = 0; i < 150; i++) begin
      case ($urandom % 4)
        0: write_port(1'($urandom % 2), W'($urandom));
        1: drive_pad(W'($urandom));
        default: read_pair(1'($urandom % 2), 1'($urandom % 2));
      endcase
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule